// File: doc/BRIEF.md
# Asynchronous Multiplexed-Bus Register Bridge

This block sits between an external host bus and an internal register bus that runs on a single 100 MHz clock. The host bus is asynchronous and carries address and data on the same 16 lines. It has active-low strobes for address-valid, chip-select, write-enable and output-enable. The bridge captures the address on the strobe that closes the address phase. It captures write data on the strobe that opens the write. Each capture goes into its own holding register, and those registers are clocked by the strobes themselves.

The three control lines cross into the system clock through a two-stage synchronizer and one more stage used for edge detection. Write-enable and output-enable are qualified with chip-select. A write is recognised when the qualified write-enable is released. A read is recognised when the qualified output-enable is asserted.

Each recognised access produces one internal strobe, exactly one cycle wide, and copies the held address, plus the held data for a write, into the system domain. The internal strobes are plain pulses with no ready or back-pressure: the register side must accept every write strobe in the cycle it appears. For a read, the register side must present its value in the cycle after the read strobe. The bridge then holds that value on its bus output. It enables the bus drivers only while chip-select and output-enable are both low.

Top module: `async_mux_bridge`

## Requirements
- R1: While reset is held, the following outputs stay at zero: `reg_wr`, `reg_rd`, `reg_addr`, `reg_wdata` and `bus_ad_out`.
- R2: Every host write (write-enable low then high, with chip-select low) yields exactly one `reg_wr` pulse, one clock wide.
- R3: During an internal strobe, `reg_addr` equals the bus value present at the rising edge of `bus_adv_n`. `reg_addr` changes only together with a strobe.
- R4: During `reg_wr`, `reg_wdata` equals the bus value present at the falling edge of `bus_we_n`. Later changes on the bus before write-enable rises have no effect.
- R5: Every host read (output-enable falling, with chip-select low) yields exactly one `reg_rd` pulse, one clock wide, with the captured address.
- R6: `bus_ad_out` takes the value of `reg_rdata` from the cycle immediately after `reg_rd`. Values of `reg_rdata` in other cycles are ignored.
- R7: `bus_ad_oe` is 1 only while `bus_cs_n` and `bus_oe_n` are both 0.
- R8: Pulses on write-enable or output-enable while chip-select is high produce no internal strobe.
- R9: `reg_wr` rises on the third rising clock edge after the release of `bus_we_n` is first visible. `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_adv_n | input | 1 | Host address-valid strobe, active low |
| bus_cs_n | input | 1 | Host chip-select, active low |
| bus_we_n | input | 1 | Host write-enable, active low |
| bus_oe_n | input | 1 | Host output-enable, active low |
| bus_ad_in | input | 16 | Multiplexed address/data lines as seen by the bridge |
| bus_ad_out | output | 16 | Read data driven back onto the lines |
| bus_ad_oe | output | 1 | Driver enable for bus_ad_out |
| reg_wr | output | 1 | Internal write strobe, one cycle |
| reg_rd | output | 1 | Internal read strobe, one cycle |
| reg_addr | output | 16 | Internal address |
| reg_wdata | output | 16 | Internal write data |
| reg_rdata | input | 16 | Read data from the register side, valid the cycle after reg_rd |

## Verification
The assertions assume that the host keeps every control level for at least three system clocks. They also assume that write-enable and output-enable are never low at the same time, and that the lines are stable around each capturing strobe edge. The bench stimulus honours these assumptions: it drives all bus pins on the falling clock edge and holds each phase for three or more cycles. It changes the bus lines only while no capturing edge is due, except for one deliberate change inside a write that checks R4.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  parameter int BUS_W = 16;
  parameter int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    CTL_OE = 2'd0,
    CTL_WE = 2'd1,
    CTL_CS = 2'd2
  } ctl_idx_e;

  localparam int CTL_N = 3;
endpackage

// File: rtl/strobe_hold.sv
module strobe_hold #(
  parameter int W = 16,
  parameter bit ON_RISE = 1'b1
) (
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (ON_RISE) begin : g_rise
      always_ff @(posedge strobe) q <= d;
    end else begin : g_fall
      always_ff @(negedge strobe) q <= d;
    end
  endgenerate
endmodule

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int N = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= chain[STAGES-1];
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/async_mux_bridge.sv
module async_mux_bridge
  import bridge_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_adv_n,
  input  logic          bus_cs_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic [DW-1:0] bus_ad_in,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  logic [DW-1:0]    addr_hold, data_hold;
  logic [CTL_N-1:0] ctl_raw, ctl_cur, ctl_prev;
  logic             wq_cur, wq_prev, rq_cur, rq_prev;
  logic             wr_evt, rd_evt, rd_dly;

  // address closes on the rising address-valid edge
  strobe_hold #(.W(DW), .ON_RISE(1'b1)) u_addr_hold (
    .strobe(bus_adv_n), .d(bus_ad_in), .q(addr_hold)
  );

  // write data is taken as write-enable opens
  strobe_hold #(.W(DW), .ON_RISE(1'b0)) u_data_hold (
    .strobe(bus_we_n), .d(bus_ad_in), .q(data_hold)
  );

  always_comb begin
    ctl_raw         = '1;
    ctl_raw[CTL_OE] = bus_oe_n;
    ctl_raw[CTL_WE] = bus_we_n;
    ctl_raw[CTL_CS] = bus_cs_n;
  end

  ctl_sync #(.N(CTL_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ctl_raw),
    .cur(ctl_cur), .prev(ctl_prev)
  );

  assign wq_cur  = ~ctl_cur[CTL_CS]  & ~ctl_cur[CTL_WE];
  assign wq_prev = ~ctl_prev[CTL_CS] & ~ctl_prev[CTL_WE];
  assign rq_cur  = ~ctl_cur[CTL_CS]  & ~ctl_cur[CTL_OE];
  assign rq_prev = ~ctl_prev[CTL_CS] & ~ctl_prev[CTL_OE];

  assign wr_evt = wq_prev & ~wq_cur;   // release of qualified write
  assign rd_evt = ~rq_prev & rq_cur;   // start of qualified read

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      rd_dly     <= 1'b0;
      bus_ad_out <= '0;
    end else begin
      reg_wr <= wr_evt;
      reg_rd <= rd_evt;
      rd_dly <= reg_rd;
      if (wr_evt || rd_evt) reg_addr  <= addr_hold;
      if (wr_evt)           reg_wdata <= data_hold;
      if (rd_dly)           bus_ad_out <= reg_rdata;
    end
  end

  assign bus_ad_oe = ~bus_cs_n & ~bus_oe_n;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [DW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] bus_ad_out
);
  assert_single_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_single_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_addr_moves_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> (reg_wr || reg_rd));

  assert_wdata_moves_with_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_wdata) |-> reg_wr);

  assert_read_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd, 2) |-> (bus_ad_out == $past(reg_rdata, 1)));

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

bind async_mux_bridge bridge_checker #(.DW(DW)) u_bridge_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_ad_out(bus_ad_out)
);

// File: tb/tb_async_mux_bridge.sv
module tb_async_mux_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {is_write, address, data}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h0012, 16'hA5C3},
    {1'b0, 16'h0012, 16'h0000},
    {1'b1, 16'hFFFF, 16'h0000},
    {1'b1, 16'h0000, 16'hFFFF},
    {1'b0, 16'h80F1, 16'h0000},
    {1'b0, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_adv_n = 1'b1, bus_cs_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [15:0] bus_ad_in = '0;
  logic [15:0] bus_ad_out, reg_addr, reg_wdata;
  logic [15:0] reg_rdata = 16'hBAD0;
  logic        bus_ad_oe, reg_wr, reg_rd;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] seen_wa = '0, seen_wd = '0, seen_ra = '0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_mux_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_adv_n(bus_adv_n), .bus_cs_n(bus_cs_n),
    .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .bus_ad_in(bus_ad_in),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] rd_val(input logic [15:0] a);
    return {~a[7:0], a[7:0]};
  endfunction

  // register-side model: value valid only in the cycle after reg_rd
  always @(posedge clk) begin
    if (reg_rd) reg_rdata <= rd_val(reg_addr);
    else        reg_rdata <= 16'hBAD0;
    if (reg_wr) begin wr_cnt <= wr_cnt + 1; seen_wa <= reg_addr; seen_wd <= reg_wdata; end
    if (reg_rd) begin rd_cnt <= rd_cnt + 1; seen_ra <= reg_addr; end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_ad_in = a; bus_adv_n = 1'b0;
    wait_clk(3);
    bus_adv_n = 1'b1;
    wait_clk(3);
  endtask

  task automatic host_write(input logic [15:0] a, input logic [15:0] d);
    int w0;
    w0 = wr_cnt;
    addr_phase(a);
    bus_ad_in = d;
    wait_clk(1);
    bus_we_n = 1'b0;
    wait_clk(3);
    bus_ad_in = ~d;          // R4: change after capture must not matter
    wait_clk(1);
    bus_we_n = 1'b1;
    wait_clk(2);
    chk("R9 wr not yet", {15'd0, reg_wr}, 16'd0);
    wait_clk(1);
    chk("R9 wr latency", {15'd0, reg_wr}, 16'd1);
    wait_clk(3);
    bus_cs_n = 1'b1;
    wait_clk(6);
    chk("R2 one wr pulse", 16'(wr_cnt - w0), 16'd1);
    chk("R3 wr addr", seen_wa, a);
    chk("R4 wr data", seen_wd, d);
  endtask

  task automatic host_read(input logic [15:0] a);
    int r0;
    r0 = rd_cnt;
    addr_phase(a);
    bus_ad_in = 16'h5A5A;
    bus_oe_n = 1'b0;
    wait_clk(8);
    chk("R7 oe driven", {15'd0, bus_ad_oe}, 16'd1);
    chk("R6 read data", bus_ad_out, rd_val(a));
    bus_oe_n = 1'b1;
    wait_clk(1);
    chk("R7 oe released", {15'd0, bus_ad_oe}, 16'd0);
    bus_cs_n = 1'b1;
    wait_clk(6);
    chk("R5 one rd pulse", 16'(rd_cnt - r0), 16'd1);
    chk("R5 rd addr", seen_ra, a);
  endtask

  initial begin
    wait_clk(4);
    chk("R1 reg_wr", {15'd0, reg_wr}, 16'd0);
    chk("R1 reg_rd", {15'd0, reg_rd}, 16'd0);
    chk("R1 reg_addr", reg_addr, 16'd0);
    chk("R1 reg_wdata", reg_wdata, 16'd0);
    chk("R1 bus_ad_out", bus_ad_out, 16'd0);
    chk("R7 idle oe", {15'd0, bus_ad_oe}, 16'd0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][32]) host_write(VEC[v][31:16], VEC[v][15:0]);
      else            host_read(VEC[v][31:16]);
    end

    // R8: strobes with chip-select high
    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      bus_ad_in = 16'h1234;
      bus_we_n = 1'b0; wait_clk(4); bus_we_n = 1'b1; wait_clk(4);
      bus_oe_n = 1'b0; wait_clk(2);
      chk("R7 oe without cs", {15'd0, bus_ad_oe}, 16'd0);
      wait_clk(2); bus_oe_n = 1'b1; wait_clk(8);
      chk("R8 no wr", 16'(wr_cnt - w0), 16'd0);
      chk("R8 no rd", 16'(rd_cnt - r0), 16'd0);
      chk("R3 addr unchanged", reg_addr, 16'h0000);
    end

    // back-to-back write then read of same address
    host_write(16'h0345, 16'h0F0F);
    host_read(16'h0345);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule